// File: doc/BRIEF.md
# Four-channel DAC command interpreter

This block sits behind a byte-level I2C slave front end and turns the stream of received bytes into updates of a four-channel DAC register bank. For every byte the front end raises a one-cycle receive strobe carrying the byte. Some cycles later it raises a one-cycle acknowledge strobe for that same byte. It also pulses a stop indication when the transfer ends. Each channel holds a 12-bit input register, a 12-bit output register that drives the converter, and a nonvolatile shadow copy. Per-channel reference-select, gain and power-down flags are also kept, along with a 3-bit device address and its nonvolatile copy.

Several command kinds share the first byte of a transfer. One fills all four channels in turn. One writes one channel per three-byte group. One walks from a chosen channel up to the last one and then saves the result. One writes a single channel and saves it. Others set the address or one flag per channel. A write that saves to the nonvolatile copy starts a modelled programming time. During that time a busy flag is high and every received byte is ignored. The output registers copy the input registers while the active-low load input is low. A write whose update flag is clear also loads its channel's output at once.

Top module: `dac_cmd_core`

## Requirements
- R1: The first byte after a stop is the command: bits 7:5 are the type, bits 4:3 the function, bits 2:1 the channel (0 = A up to 3 = D) and bit 0 the update-hold flag. Type 111, or type 010 with function 01, makes every further byte up to the next stop have no effect.
- R2: Type 00x is a fast write, made of byte pairs for channels A, B, C and D in that order. The first byte of a pair carries power-down in bit 4 and code bits 11:8 in bits 3:0. The second byte carries code bits 7:0. Bytes after channel D's pair are ignored until stop, and the nonvolatile copy is not changed.
- R3: Type 010 with function 00 is a multi-write of three-byte groups: command, data-high, data-low. The data-high byte holds reference-select in bit 7, power-down in bit 6, gain in bit 5 and code bits 11:8 in bits 3:0. Each group writes only the channel named in its own command byte, and the nonvolatile copy is not changed.
- R4: Type 010 with function 10 writes data-high/data-low pairs from the selected channel up to channel D. The nonvolatile copy of each of those channels then takes its new code, and the channels below the start keep theirs.
- R5: Type 010 with function 11 writes one data-high/data-low pair to the selected channel, and that channel's nonvolatile copy takes the new code.
- R6: A channel's data commits on the acknowledge of its data-low byte. Receiving that byte alone changes no output.
- R7: In the walk of R4, no nonvolatile copy changes before the acknowledge of channel D's data-low byte. After it, all of them change together.
- R8: Type 011 loads the device address from bits 2:0 at its acknowledge. The nonvolatile address copy follows one cycle later, and programming starts.
- R9: Types 100, 110 and 101 load reference-select, gain and power-down for all channels from bits 3:0, with bit 3 for channel A and bit 0 for channel D. Several such bytes may follow one another in one transfer.
- R10: A nonvolatile write holds busy high for NV_CYCLES (64) clock cycles. Every byte acknowledged during that time has no effect.
- R11: While the load input is low, every output register takes its input register each cycle. A multi, walk or single write with the update-hold flag at 0 loads its channel's output at commit. A fast write never loads an output by itself.
- R12: A stop before a group's data-low acknowledge discards that group. Channels committed earlier in the transfer keep their new codes.
- R13: Reset clears all codes, flags, addresses and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_valid | input | 1 | One-cycle strobe: byte_data holds a received byte |
| byte_data | input | 8 | Received byte |
| byte_ack | input | 1 | One-cycle acknowledge strobe for the last received byte |
| bus_stop | input | 1 | One-cycle stop indication |
| ldac_n | input | 1 | Active-low load: outputs copy input registers |
| out_code | output | CH*DW | Output codes, channel A in bits 11:0 |
| nv_code | output | CH*DW | Nonvolatile codes, same packing |
| dev_addr | output | 3 | Device address |
| nv_addr | output | 3 | Nonvolatile device address |
| vref_sel | output | CH | Reference-select, bit i for channel i |
| gain_sel | output | CH | Gain, bit i for channel i |
| pwr_down | output | CH | Power-down, bit i for channel i |
| busy | output | 1 | Nonvolatile programming in progress |

## Verification
The multi-write is swept over every channel with the update-hold flag at both values. This separates an immediate output load from a load that waits for the load input. The output is also sampled between receipt and acknowledge of the last byte. The walk is run from each of the four start channels, and the saved copies are compared both mid-walk and after busy clears; this shows which channels are saved and when. All sixteen flag patterns go through the three flag commands, which tests the bit-to-channel order. Stops placed mid-group, command bytes sent during busy, and unsupported codes must all leave the outputs and flags untouched.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  typedef enum logic [2:0] {
    PH_CMD,   // expecting a command byte
    PH_FHI,   // fast write: high byte of a pair
    PH_FLO,   // fast write: low byte of a pair
    PH_CFG,   // data-high byte of a group
    PH_LO,    // data-low byte of a group
    PH_SKIP   // ignore until stop
  } phase_t;

  typedef enum logic [1:0] {
    MD_MULTI,
    MD_SEQ,
    MD_SINGLE
  } mode_t;
endpackage

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode import dac_cmd_pkg::*; #(
  parameter int CH = 4,
  parameter int DW = 12,
  localparam int CW = $clog2(CH),
  localparam int HW = DW - 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          byte_valid,
  input  logic [7:0]    byte_data,
  input  logic          byte_ack,
  input  logic          bus_stop,
  output logic          wr_en,
  output logic          wr_fast,
  output logic          wr_upd,
  output logic [CW-1:0] wr_ch,
  output logic [DW-1:0] wr_code,
  output logic          wr_vref,
  output logic          wr_gain,
  output logic          wr_pd,
  output logic [2:0]    glob_en,
  output logic [CH-1:0] glob_bits,
  output logic          addr_en,
  output logic [2:0]    addr_val,
  output logic          nv_start,
  output logic          nv_addr_go,
  output logic [CH-1:0] nv_mask
);
  phase_t        ph, ph_n;
  mode_t         md, md_n;
  logic [CW-1:0] ch, ch_n, st, st_n;
  logic          ud, ud_n, v, v_n, g, g_n, p, p_n;
  logic [HW-1:0] hi, hi_n;
  logic [7:0]    hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= PH_CMD; md <= MD_MULTI; ch <= '0; st <= '0;
      ud <= 1'b0; v <= 1'b0; g <= 1'b0; p <= 1'b0; hi <= '0; hold <= '0;
    end else begin
      if (byte_valid && !busy) hold <= byte_data;
      ph <= ph_n; md <= md_n; ch <= ch_n; st <= st_n;
      ud <= ud_n; v <= v_n; g <= g_n; p <= p_n; hi <= hi_n;
    end
  end

  always_comb begin
    ph_n = ph; md_n = md; ch_n = ch; st_n = st;
    ud_n = ud; v_n = v; g_n = g; p_n = p; hi_n = hi;
    wr_en = 1'b0; wr_fast = 1'b0; wr_upd = !ud; wr_ch = ch;
    wr_code = {hi, hold}; wr_vref = v; wr_gain = g; wr_pd = p;
    glob_en = 3'b000; glob_bits = hold[CH-1:0];
    addr_en = 1'b0; addr_val = hold[2:0];
    nv_start = 1'b0; nv_addr_go = 1'b0; nv_mask = '0;
    if (byte_ack && !busy) begin
      case (ph)
        PH_CMD: begin
          if (hold[7:6] == 2'b00) begin
            p_n = hold[4]; hi_n = hold[HW-1:0]; ch_n = '0; ph_n = PH_FLO;
          end else begin
            case (hold[7:5])
              3'b010: begin
                st_n = hold[2:1]; ch_n = hold[2:1]; ud_n = hold[0]; ph_n = PH_CFG;
                case (hold[4:3])
                  2'b00:   md_n = MD_MULTI;
                  2'b10:   md_n = MD_SEQ;
                  2'b11:   md_n = MD_SINGLE;
                  default: ph_n = PH_SKIP;
                endcase
              end
              3'b011: begin
                addr_en = 1'b1; nv_start = 1'b1; nv_addr_go = 1'b1; ph_n = PH_SKIP;
              end
              3'b100:  glob_en = 3'b100;
              3'b110:  glob_en = 3'b010;
              3'b101:  glob_en = 3'b001;
              default: ph_n = PH_SKIP;
            endcase
          end
        end
        PH_FHI: begin
          p_n = hold[4]; hi_n = hold[HW-1:0]; ph_n = PH_FLO;
        end
        PH_FLO: begin
          wr_en = 1'b1; wr_fast = 1'b1; wr_upd = 1'b0;
          if (ch == CW'(CH - 1)) ph_n = PH_SKIP;
          else begin ch_n = ch + 1'b1; ph_n = PH_FHI; end
        end
        PH_CFG: begin
          v_n = hold[7]; p_n = hold[6]; g_n = hold[5]; hi_n = hold[HW-1:0]; ph_n = PH_LO;
        end
        PH_LO: begin
          wr_en = 1'b1;
          case (md)
            MD_SEQ: begin
              if (ch == CW'(CH - 1)) begin
                nv_start = 1'b1; ph_n = PH_SKIP;
                for (int i = 0; i < CH; i++) nv_mask[i] = (i >= int'(st));
              end else begin
                ch_n = ch + 1'b1; ph_n = PH_CFG;
              end
            end
            MD_SINGLE: begin
              nv_start = 1'b1; nv_mask[ch] = 1'b1; ph_n = PH_SKIP;
            end
            default: ph_n = PH_CMD;
          endcase
        end
        default: ;
      endcase
    end
    if (bus_stop) ph_n = PH_CMD;
  end
endmodule

// File: rtl/dac_chan_bank.sv
module dac_chan_bank #(
  parameter int CH = 4,
  parameter int DW = 12,
  localparam int CW = $clog2(CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ldac_n,
  input  logic            wr_en,
  input  logic            wr_fast,
  input  logic            wr_upd,
  input  logic [CW-1:0]   wr_ch,
  input  logic [DW-1:0]   wr_code,
  input  logic            wr_vref,
  input  logic            wr_gain,
  input  logic            wr_pd,
  input  logic [2:0]      glob_en,
  input  logic [CH-1:0]   glob_bits,
  input  logic            addr_en,
  input  logic [2:0]      addr_val,
  input  logic            nv_start,
  input  logic            nv_addr_go,
  input  logic [CH-1:0]   nv_mask,
  output logic [CH*DW-1:0] out_code,
  output logic [CH*DW-1:0] nv_code,
  output logic [2:0]      dev_addr,
  output logic [2:0]      nv_addr,
  output logic [CH-1:0]   vref_sel,
  output logic [CH-1:0]   gain_sel,
  output logic [CH-1:0]   pwr_down
);
  logic [DW-1:0] in_q  [CH];
  logic [DW-1:0] out_q [CH];
  logic [DW-1:0] nv_q  [CH];
  logic [CH-1:0] mask_q;
  logic          addr_go_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < CH; i++) begin
        in_q[i] <= '0; out_q[i] <= '0; nv_q[i] <= '0;
      end
      vref_sel <= '0; gain_sel <= '0; pwr_down <= '0;
      dev_addr <= '0; nv_addr <= '0; mask_q <= '0; addr_go_q <= 1'b0;
    end else begin
      for (int i = 0; i < CH; i++) begin
        if (!ldac_n) out_q[i] <= in_q[i];
        if (mask_q[i]) nv_q[i] <= in_q[i];
        if (glob_en[2]) vref_sel[i] <= glob_bits[CH-1-i];
        if (glob_en[1]) gain_sel[i] <= glob_bits[CH-1-i];
        if (glob_en[0]) pwr_down[i] <= glob_bits[CH-1-i];
      end
      if (wr_en) begin
        in_q[wr_ch]     <= wr_code;
        pwr_down[wr_ch] <= wr_pd;
        if (!wr_fast) begin
          vref_sel[wr_ch] <= wr_vref;
          gain_sel[wr_ch] <= wr_gain;
        end
        if (wr_upd) out_q[wr_ch] <= wr_code;
      end
      if (addr_en) dev_addr <= addr_val;
      mask_q    <= nv_start ? nv_mask : '0;
      addr_go_q <= nv_addr_go;
      if (addr_go_q) nv_addr <= dev_addr;
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_flat
    assign out_code[i*DW +: DW] = out_q[i];
    assign nv_code[i*DW +: DW]  = nv_q[i];
  end
endmodule

// File: rtl/dac_nv_timer.sv
module dac_nv_timer #(
  parameter int NV_CYCLES = 64,
  localparam int TW = $clog2(NV_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic nv_start,
  output logic busy
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0; cnt <= '0;
    end else if (nv_start) begin
      busy <= 1'b1; cnt <= TW'(NV_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core #(
  parameter int CH        = 4,
  parameter int DW        = 12,
  parameter int NV_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             byte_valid,
  input  logic [7:0]       byte_data,
  input  logic             byte_ack,
  input  logic             bus_stop,
  input  logic             ldac_n,
  output logic [CH*DW-1:0] out_code,
  output logic [CH*DW-1:0] nv_code,
  output logic [2:0]       dev_addr,
  output logic [2:0]       nv_addr,
  output logic [CH-1:0]    vref_sel,
  output logic [CH-1:0]    gain_sel,
  output logic [CH-1:0]    pwr_down,
  output logic             busy
);
  localparam int CW = $clog2(CH);

  logic          wr_en, wr_fast, wr_upd, wr_vref, wr_gain, wr_pd;
  logic [CW-1:0] wr_ch;
  logic [DW-1:0] wr_code;
  logic [2:0]    glob_en, addr_val;
  logic [CH-1:0] glob_bits, nv_mask;
  logic          addr_en, nv_start, nv_addr_go;

  dac_cmd_decode #(.CH(CH), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .busy(busy), .byte_valid(byte_valid),
    .byte_data(byte_data), .byte_ack(byte_ack), .bus_stop(bus_stop),
    .wr_en(wr_en), .wr_fast(wr_fast), .wr_upd(wr_upd), .wr_ch(wr_ch),
    .wr_code(wr_code), .wr_vref(wr_vref), .wr_gain(wr_gain), .wr_pd(wr_pd),
    .glob_en(glob_en), .glob_bits(glob_bits), .addr_en(addr_en),
    .addr_val(addr_val), .nv_start(nv_start), .nv_addr_go(nv_addr_go),
    .nv_mask(nv_mask)
  );

  dac_chan_bank #(.CH(CH), .DW(DW)) u_bank (
    .clk(clk), .rst(rst), .ldac_n(ldac_n), .wr_en(wr_en), .wr_fast(wr_fast),
    .wr_upd(wr_upd), .wr_ch(wr_ch), .wr_code(wr_code), .wr_vref(wr_vref),
    .wr_gain(wr_gain), .wr_pd(wr_pd), .glob_en(glob_en), .glob_bits(glob_bits),
    .addr_en(addr_en), .addr_val(addr_val), .nv_start(nv_start),
    .nv_addr_go(nv_addr_go), .nv_mask(nv_mask), .out_code(out_code),
    .nv_code(nv_code), .dev_addr(dev_addr), .nv_addr(nv_addr),
    .vref_sel(vref_sel), .gain_sel(gain_sel), .pwr_down(pwr_down)
  );

  dac_nv_timer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .nv_start(nv_start), .busy(busy)
  );
endmodule

// File: rtl/dac_cmd_core_chk.sv
module dac_cmd_core_chk #(
  parameter int CH        = 4,
  parameter int DW        = 12,
  parameter int NV_CYCLES = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_ack,
  input logic             ldac_n,
  input logic             busy,
  input logic [CH*DW-1:0] out_code,
  input logic [CH*DW-1:0] nv_code,
  input logic [2:0]       dev_addr,
  input logic [CH-1:0]    vref_sel,
  input logic [CH-1:0]    gain_sel,
  input logic [CH-1:0]    pwr_down
);
  int unsigned busy_run;

  always_ff @(posedge clk) begin
    if (rst) busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else busy_run <= 0;
  end

  // R10: busy lasts exactly NV_CYCLES cycles
  a_r10_busy_len: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> busy_run == NV_CYCLES);

  // R10: commands seen during busy change no address or flag
  a_r10_lockout_cfg: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(dev_addr) && $stable(vref_sel)
                               && $stable(gain_sel) && $stable(pwr_down)));

  // R7: nonvolatile codes move only on the first busy cycle
  a_r7_nv_once: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(busy, 2)) |-> $stable(nv_code));

  // R11: with load high and no acknowledge, outputs hold
  a_r11_out_hold: assert property (@(posedge clk) disable iff (rst)
    (ldac_n && !byte_ack) |=> $stable(out_code));

  // R13: reset clears busy and outputs
  a_r13_reset: assert property (@(posedge clk)
    rst |=> (!busy && out_code == '0 && nv_code == '0));
endmodule

bind dac_cmd_core dac_cmd_core_chk #(.CH(CH), .DW(DW), .NV_CYCLES(NV_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .byte_ack(byte_ack), .ldac_n(ldac_n), .busy(busy),
  .out_code(out_code), .nv_code(nv_code), .dev_addr(dev_addr),
  .vref_sel(vref_sel), .gain_sel(gain_sel), .pwr_down(pwr_down)
);

// File: tb/dac_cmd_core_bench.sv
module dac_cmd_core_bench;
  localparam int CH = 4, DW = 12, NV = 64;

  logic clk = 1'b0, rst = 1'b1;
  logic byte_valid = 1'b0, byte_ack = 1'b0, bus_stop = 1'b0, ldac_n = 1'b1;
  logic [7:0] byte_data = '0;
  logic [CH*DW-1:0] out_code, nv_code;
  logic [2:0] dev_addr, nv_addr;
  logic [CH-1:0] vref_sel, gain_sel, pwr_down;
  logic busy;

  always #10 clk = ~clk;

  dac_cmd_core #(.CH(CH), .DW(DW), .NV_CYCLES(NV)) u_dac_cmd_core (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ack(byte_ack), .bus_stop(bus_stop), .ldac_n(ldac_n),
    .out_code(out_code), .nv_code(nv_code), .dev_addr(dev_addr),
    .nv_addr(nv_addr), .vref_sel(vref_sel), .gain_sel(gain_sel),
    .pwr_down(pwr_down), .busy(busy)
  );

  int tests = 0, fails = 0;
  bit done = 0;
  logic [DW-1:0] e_in [CH], e_out [CH], e_nv [CH];
  logic [CH-1:0] e_vref = '0, e_gain = '0, e_pd = '0;

  function automatic logic [CH*DW-1:0] pk(int which);
    logic [CH*DW-1:0] r;
    for (int i = 0; i < CH; i++)
      r[i*DW +: DW] = (which == 0) ? e_out[i] : (which == 1) ? e_nv[i] : e_in[i];
    return r;
  endfunction

  function automatic logic [DW-1:0] code_of(int k);
    return DW'((k * 695 + 309) % 4096);
  endfunction

  // R1: command byte layout {type, function, channel, update-hold}
  function automatic logic [7:0] cmd(logic [2:0] t, logic [1:0] f, int s, logic u);
    return {t, f, 2'(s), u};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rx_only(logic [7:0] b);
    @(negedge clk) begin byte_valid = 1'b1; byte_data = b; end
    @(negedge clk) byte_valid = 1'b0;
  endtask

  task automatic ack_only();
    @(negedge clk) byte_ack = 1'b1;
    @(negedge clk) byte_ack = 1'b0;
  endtask

  task automatic put(logic [7:0] b);
    rx_only(b); ack_only();
  endtask

  task automatic stop_pulse();
    @(negedge clk) bus_stop = 1'b1;
    @(negedge clk) bus_stop = 1'b0;
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0; tick(2); ldac_n = 1'b1; tick(1);
    for (int i = 0; i < CH; i++) e_out[i] = e_in[i];
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (busy && n < 500) begin tick(1); n++; end
  endtask

  // data-high byte of a group: {vref, pd, gain, 0, code[11:8]}
  task automatic group(int c, logic [DW-1:0] code, logic v, logic g, logic p);
    put({v, p, g, 1'b0, code[11:8]});
    put(code[7:0]);
    e_in[c] = code; e_vref[c] = v; e_gain[c] = g; e_pd[c] = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL R10 watchdog actual=hung expected=finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [DW-1:0] cd;
    for (int i = 0; i < CH; i++) begin e_in[i] = '0; e_out[i] = '0; e_nv[i] = '0; end
    tick(3); rst = 1'b0; tick(1);

    // R13 reset state
    chk("R13 out", out_code, '0);
    chk("R13 nv", nv_code, '0);
    chk("R13 busy/addr", {busy, dev_addr, nv_addr, vref_sel, gain_sel, pwr_down}, '0);

    // R2 fast write A..D, load input high: nothing reaches the outputs
    stop_pulse();
    for (int c = 0; c < CH; c++) begin
      cd = code_of(c + 1);
      put({2'b00, 1'b0, 1'(c & 1), cd[11:8]});
      put(cd[7:0]);
      e_in[c] = cd; e_pd[c] = 1'(c & 1);
    end
    put(8'h0A); put(8'hBC);      // beyond channel D: ignored
    stop_pulse(); tick(1);
    chk("R11 fast no self-load", out_code, pk(0));
    chk("R2 fast pd", pwr_down, e_pd);
    pulse_ldac();
    chk("R2 fast order A..D", out_code, pk(0));
    chk("R2 fast nv untouched", nv_code, pk(1));

    // R11 fast write with load held low
    ldac_n = 1'b0;
    cd = code_of(40);
    put({2'b00, 1'b0, 1'b0, cd[11:8]}); put(cd[7:0]);
    e_in[0] = cd; e_pd[0] = 1'b0; tick(2);
    for (int i = 0; i < CH; i++) e_out[i] = e_in[i];
    chk("R11 fast load low", out_code, pk(0));
    ldac_n = 1'b1; stop_pulse();

    // R3/R6/R11 multi-write sweep over channels and update-hold
    for (int c = 0; c < CH; c++) begin
      for (int u = 0; u < 2; u++) begin
        cd = code_of(10 + c * 2 + u);
        put(cmd(3'b010, 2'b00, c, 1'(u)));
        put({1'(c & 1), 1'(c >> 1), 1'(u), 1'b0, cd[11:8]});
        rx_only(cd[7:0]); tick(2);
        chk("R6 no commit before ack", out_code, pk(0));
        ack_only(); tick(1);
        e_in[c] = cd; e_vref[c] = 1'(c & 1); e_pd[c] = 1'(c >> 1); e_gain[c] = 1'(u);
        if (u == 0) e_out[c] = cd;
        chk("R3 R11 multi out", out_code, pk(0));
        chk("R3 multi flags", {vref_sel, gain_sel, pwr_down}, {e_vref, e_gain, e_pd});
      end
    end
    stop_pulse(); pulse_ldac();
    chk("R3 multi inputs", out_code, pk(0));
    chk("R3 multi nv untouched", nv_code, pk(1));

    // R4/R7 walk from every start channel, update-hold set
    for (int s = 0; s < CH; s++) begin
      stop_pulse();
      put(cmd(3'b010, 2'b10, s, 1'b1));
      for (int c = s; c < CH; c++) begin
        group(c, code_of(20 + s * 4 + c), 1'b1, 1'(c & 1), 1'b0);
        if (c < CH - 1) begin tick(2); chk("R7 nv held mid-walk", nv_code, pk(1)); end
      end
      wait_ready(n);
      chk("R10 busy length", 64'(n), 64'(NV));
      for (int c = s; c < CH; c++) e_nv[c] = e_in[c];
      chk("R4 walk nv", nv_code, pk(1));
      chk("R11 walk hold", out_code, pk(0));
    end

    // R5 single write per channel, update-hold clear
    for (int c = 0; c < CH; c++) begin
      stop_pulse();
      put(cmd(3'b010, 2'b11, c, 1'b0));
      group(c, code_of(50 + c), 1'b0, 1'b1, 1'b0);
      e_out[c] = e_in[c];
      wait_ready(n);
      e_nv[c] = e_in[c];
      chk("R5 single nv", nv_code, pk(1));
      chk("R5 R11 single out", out_code, pk(0));
    end

    // R10 lockout: commands sent during busy are ignored
    stop_pulse();
    put(cmd(3'b010, 2'b11, 2, 1'b1));
    group(2, code_of(60), 1'b0, 1'b0, 1'b1);
    stop_pulse();
    put({3'b100, 1'b0, ~e_vref[0], ~e_vref[1], ~e_vref[2], ~e_vref[3]});
    put(8'h0F); put(8'hFF);
    wait_ready(n);
    e_nv[2] = e_in[2];
    chk("R10 flags locked", vref_sel, e_vref);
    pulse_ldac();
    chk("R10 inputs locked", out_code, pk(0));
    chk("R10 nv", nv_code, pk(1));

    // R8 address
    stop_pulse();
    put(8'b011_00_101);
    chk("R8 dev addr", dev_addr, 3'd5);
    wait_ready(n);
    chk("R8 nv addr", nv_addr, 3'd5);

    // R9 all flag patterns
    stop_pulse();
    for (int k = 0; k < 16; k++) begin
      logic [3:0] pt;
      pt = 4'(k);
      put({3'b100, 1'b0, pt}); put({3'b110, 1'b0, ~pt}); put({3'b101, 1'b0, pt ^ 4'b0011});
      for (int i = 0; i < CH; i++) begin
        e_vref[i] = pt[3-i]; e_gain[i] = ~pt[3-i]; e_pd[i] = pt[3-i] ^ (i >= 2);
      end
      chk("R9 flags", {vref_sel, gain_sel, pwr_down}, {e_vref, e_gain, e_pd});
    end

    // R12 stop before the data-low acknowledge
    stop_pulse();
    put(cmd(3'b010, 2'b00, 1, 1'b0));
    put({~e_vref[1], ~e_pd[1], ~e_gain[1], 1'b0, 4'hA});
    stop_pulse(); pulse_ldac();
    chk("R12 group dropped", out_code, pk(0));
    chk("R12 flags kept", {vref_sel, gain_sel, pwr_down}, {e_vref, e_gain, e_pd});
    cd = code_of(70);
    put({2'b00, 1'b0, 1'b1, cd[11:8]}); put(cd[7:0]);
    e_in[0] = cd; e_pd[0] = 1'b1;
    put({2'b00, 1'b0, 1'b0, 4'h3});
    stop_pulse(); pulse_ldac();
    chk("R12 earlier channel kept", out_code, pk(0));

    // R1 unsupported codes
    stop_pulse();
    put(8'b111_00000); put({3'b100, 1'b0, ~e_vref[0], ~e_vref[1], ~e_vref[2], ~e_vref[3]});
    chk("R1 type 111 ignored", vref_sel, e_vref);
    stop_pulse();
    put(cmd(3'b010, 2'b01, 3, 1'b0)); put(8'h8C); put(8'h55);
    stop_pulse(); pulse_ldac();
    chk("R1 function 01 ignored", out_code, pk(0));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule